// File: doc/BRIEF.md
# Wide Constant Prefix Merger

This block sits in front of an instruction queue and assembles wide immediate constants. An immediate instruction holds only 21 bits of constant. Software can place up to four prefix instructions ahead of it, and each prefix carries a 32-bit payload. The block stores those payloads as pending upper bits. When the consuming immediate instruction arrives with its "prefixed" flag set, the block joins the pending bits with the instruction's own low 21 bits. It then emits a sign-extended 128-bit constant together with the instruction's tag.

The bundle break bit enforces serialisation. Every prefix must start its own queue cycle, and so must every flagged consumer. A slot of either kind whose break bit is clear is rejected. As a result, a constant built from four prefixes takes five input cycles to queue.

Every input slot is treated as either a prefix or an immediate consumer. All results are registered, so each one appears one cycle after its slot.

Top module: `imm_prefix_merge`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, o_valid, o_ovf and o_ser_err are 0, o_const is 0 and no prefix is pending.
- R2: A consumer whose in_has_pfx bit is 0 emits its 21-bit in_imm sign-extended from bit 20 to 128 bits, whatever prefixes are pending.
- R3: Bits 20:0 of every emitted constant equal the consumer's in_imm.
- R4: With one pending prefix and in_has_pfx=1, o_const[52:21] is that prefix payload and bit 52 is sign-extended through bit 127.
- R5: Prefix payloads fill 32-bit fields in order of arrival: the first prefix fills bits 52:21, the second 84:53, the third 116:85. The top bit of the highest filled field is sign-extended through bit 127.
- R6: With four pending prefixes, bits 127:117 take bits 10:0 of the fourth payload and bits 31:11 of that payload are discarded.
- R7: A prefix that arrives while four are already pending is dropped. It raises o_ovf for exactly one cycle, and the four pending payloads stay intact for the next consumer.
- R8: Emitting a consumer clears all pending prefixes, so a following flagged consumer with no new prefix yields sign-extended in_imm.
- R9: A cycle with flush=1 discards all pending prefixes and ignores that cycle's slot: it produces no output pulse.
- R10: A prefix, or a consumer with in_has_pfx=1, that arrives with in_brk=0 is dropped. It raises o_ser_err for one cycle, emits no o_valid and clears the pending prefixes.
- R11: o_valid pulses for exactly one cycle, one cycle after a consumer slot, with o_tag equal to that slot's in_tag. A prefix slot never produces o_valid.
- R12: In any cycle, at most one of o_valid, o_ovf and o_ser_err is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard pending prefixes and ignore this cycle's slot |
| in_valid | input | 1 | A slot is presented this cycle |
| in_pfx | input | 1 | 1 = prefix slot, 0 = immediate consumer |
| in_brk | input | 1 | Bundle break bit: the slot starts a new queue cycle |
| in_has_pfx | input | 1 | Consumer flag: prefixes precede this instruction |
| in_pay | input | 32 | Prefix payload |
| in_imm | input | 21 | Consumer low immediate |
| in_tag | input | 8 | Consumer tag passed to the output |
| o_valid | output | 1 | Merged constant is valid |
| o_tag | output | 8 | Tag of the emitted consumer |
| o_const | output | 128 | Merged, sign-extended constant |
| o_ovf | output | 1 | A fifth prefix was dropped |
| o_ser_err | output | 1 | A slot violated the break-bit rule and was dropped |

## Verification
The bench sweeps chain lengths from zero to four prefixes, with payload patterns whose top field is both positive and negative. This exposes a design that extends from the wrong bit, or that places fields in reverse arrival order. A four-prefix chain with a set bit in the discarded upper part of the last payload catches a merge that fails to truncate at bit 127. A fifth prefix followed by a consumer shows whether an overflow corrupts the pending fields or overwrites the last one. Back-to-back flagged consumers, flushes and break-bit violations show whether stale upper bits leak into a later constant.

// File: rtl/imm_prefix_merge.sv
module imm_prefix_merge #(
  parameter int LOW_W   = 21,
  parameter int PFX_W   = 32,
  parameter int MAX_PFX = 4,
  parameter int OUT_W   = 128,
  parameter int TAG_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic             in_pfx,
  input  logic             in_brk,
  input  logic             in_has_pfx,
  input  logic [PFX_W-1:0] in_pay,
  input  logic [LOW_W-1:0] in_imm,
  input  logic [TAG_W-1:0] in_tag,
  output logic             o_valid,
  output logic [TAG_W-1:0] o_tag,
  output logic [OUT_W-1:0] o_const,
  output logic             o_ovf,
  output logic             o_ser_err
);
  localparam int PEND_W = MAX_PFX * PFX_W;
  localparam int CAT_W  = LOW_W + PEND_W;
  localparam int CNT_W  = $clog2(MAX_PFX + 1);
  localparam int EXT_W  = CAT_W + OUT_W;

  logic [PEND_W-1:0] pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OUT_W-1:0]  merged;
  logic [EXT_W-1:0]  catx;

  wire needs_brk = in_pfx | in_has_pfx;
  wire full      = (cnt_q == CNT_W'(MAX_PFX));

  assign catx = {{OUT_W{1'b0}}, pend_q, in_imm};

  always_comb begin
    int top;
    top = LOW_W;
    if (in_has_pfx) top = LOW_W + int'(cnt_q) * PFX_W;
    if (top > OUT_W) top = OUT_W;
    for (int i = 0; i < OUT_W; i++)
      merged[i] = (i < top) ? catx[i] : catx[top-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      cnt_q     <= '0;
      o_valid   <= 1'b0;
      o_tag     <= '0;
      o_const   <= '0;
      o_ovf     <= 1'b0;
      o_ser_err <= 1'b0;
    end else begin
      o_valid   <= 1'b0;
      o_ovf     <= 1'b0;
      o_ser_err <= 1'b0;
      if (flush) begin
        pend_q <= '0;
        cnt_q  <= '0;
      end else if (in_valid) begin
        if (needs_brk && !in_brk) begin
          o_ser_err <= 1'b1;
          pend_q    <= '0;
          cnt_q     <= '0;
        end else if (in_pfx) begin
          if (full) begin
            o_ovf <= 1'b1;
          end else begin
            for (int k = 0; k < MAX_PFX; k++)
              if (cnt_q == CNT_W'(k)) pend_q[k*PFX_W +: PFX_W] <= in_pay;
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          o_valid <= 1'b1;
          o_const <= merged;
          o_tag   <= in_tag;
          pend_q  <= '0;
          cnt_q   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/imm_prefix_merge_chk.sv
module imm_prefix_merge_chk #(
  parameter int LOW_W = 21,
  parameter int PFX_W = 32,
  parameter int OUT_W = 128,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_pfx,
  input logic             in_has_pfx,
  input logic [LOW_W-1:0] in_imm,
  input logic [TAG_W-1:0] in_tag,
  input logic             o_valid,
  input logic [TAG_W-1:0] o_tag,
  input logic [OUT_W-1:0] o_const,
  input logic             o_ovf,
  input logic             o_ser_err
);
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({o_valid, o_ovf, o_ser_err}));

  p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> o_const[LOW_W-1:0] == $past(in_imm));

  p_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> o_tag == $past(in_tag));

  p_noflag_sext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !$past(in_has_pfx)) |->
      ((&o_const[OUT_W-1:LOW_W-1]) || !(|o_const[OUT_W-1:LOW_W-1])));

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !(o_valid || o_ovf || o_ser_err));

  p_pfx_no_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_pfx) |-> !o_valid);
endmodule

bind imm_prefix_merge imm_prefix_merge_chk #(
  .LOW_W(LOW_W), .PFX_W(PFX_W), .OUT_W(OUT_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .in_pfx(in_pfx), .in_has_pfx(in_has_pfx), .in_imm(in_imm), .in_tag(in_tag),
  .o_valid(o_valid), .o_tag(o_tag), .o_const(o_const), .o_ovf(o_ovf),
  .o_ser_err(o_ser_err)
);

// File: tb/imm_prefix_merge_tb_top.sv
`timescale 1ns/1ps
module imm_prefix_merge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, in_valid = 1'b0, in_pfx = 1'b0, in_brk = 1'b0, in_has_pfx = 1'b0;
  logic [31:0] in_pay = '0;
  logic [20:0] in_imm = '0;
  logic [7:0] in_tag = '0;
  logic o_valid, o_ovf, o_ser_err;
  logic [7:0] o_tag;
  logic [127:0] o_const;

  int checks = 0;
  int fails = 0;
  logic [31:0] pays [4];

  always #10 clk = ~clk;

  imm_prefix_merge dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_pfx(in_pfx),
    .in_brk(in_brk), .in_has_pfx(in_has_pfx), .in_pay(in_pay), .in_imm(in_imm),
    .in_tag(in_tag), .o_valid(o_valid), .o_tag(o_tag), .o_const(o_const),
    .o_ovf(o_ovf), .o_ser_err(o_ser_err)
  );

  function automatic logic [127:0] expect_const(int k, logic [20:0] imm);
    logic [148:0] v;
    logic [127:0] r;
    int w;
    v = '0;
    v[20:0] = imm;
    for (int j = 0; j < k; j++) v[21 + 32*j +: 32] = pays[j];
    w = 21 + 32*k;
    if (w > 128) w = 128;
    for (int i = 0; i < 128; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slot(input logic v, input logic p, input logic b, input logic h,
                      input logic [31:0] pay, input logic [20:0] imm, input logic [7:0] tag,
                      input logic fl);
    in_valid = v; in_pfx = p; in_brk = b; in_has_pfx = h;
    in_pay = pay; in_imm = imm; in_tag = tag; flush = fl;
    @(negedge clk);
    in_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic send_pfx(input logic [31:0] pay, input string req);
    slot(1, 1, 1, 0, pay, '0, '0, 0);
    chk({125'd0, o_valid, o_ovf, o_ser_err}, 128'd0, req);
  endtask

  task automatic consume(input logic h, input logic [20:0] imm, input logic [7:0] tag,
                         input logic [127:0] exp, input string req);
    slot(1, 0, 1, h, '0, imm, tag, 0);
    chk({125'd0, o_valid, o_ovf, o_ser_err}, 128'd4, {req, " valid"});
    chk(o_const, exp, req);
    chk({120'd0, o_tag}, {120'd0, tag}, "R11 tag");
    @(negedge clk);
    chk({127'd0, o_valid}, 128'd0, "R11 single pulse");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [20:0] imm;
    @(negedge clk);
    chk({o_const, 3'b0} | {125'd0, o_valid, o_ovf, o_ser_err}, 128'd0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({125'd0, o_valid, o_ovf, o_ser_err}, 128'd0, "R1 after reset");
    for (int i = 0; i < 4; i++) pays[i] = '0;
    consume(1, 21'h1ABCDE, 8'h11, expect_const(0, 21'h1ABCDE), "R1 R8 no pending");

    for (int k = 0; k <= 4; k++) begin
      for (int pat = 0; pat < 8; pat++) begin
        for (int j = 0; j < 4; j++) begin
          pays[j] = (32'h9E3779B9 * (pat * 5 + j + 1)) ^ (32'h01000193 * j);
          if (pat[0]) pays[j][31] = 1'b1; else pays[j][31] = 1'b0;
          if (j == 3 && pat[1]) pays[j][10] = ~pays[j][10];
        end
        imm = 21'(32'h5A5A5 * (pat + 1) + k);
        if (pat[2]) imm[20] = ~imm[20];
        for (int j = 0; j < k; j++) send_pfx(pays[j], "R11 prefix quiet");
        if (k == 0) consume(pat[0], imm, 8'(pat), expect_const(0, imm), "R2 R3 no prefix");
        else if (k == 1) consume(1, imm, 8'(pat + 16), expect_const(1, imm), "R4 one prefix");
        else if (k < 4) consume(1, imm, 8'(pat + 32), expect_const(k, imm), "R5 chain order");
        else consume(1, imm, 8'(pat + 48), expect_const(4, imm), "R6 full width");
      end
    end

    for (int j = 0; j < 4; j++) pays[j] = 32'hF0000000 | (32'h1111 * (j + 3));
    for (int j = 0; j < 4; j++) send_pfx(pays[j], "R11 prefix quiet");
    slot(1, 1, 1, 0, 32'hDEADBEEF, '0, '0, 0);
    chk({125'd0, o_valid, o_ovf, o_ser_err}, 128'd2, "R7 overflow pulse");
    @(negedge clk);
    chk({127'd0, o_ovf}, 128'd0, "R7 overflow one cycle");
    consume(1, 21'h00321, 8'hA7, expect_const(4, 21'h00321), "R7 pending kept");
    consume(1, 21'h100321, 8'hA8, expect_const(0, 21'h100321), "R8 cleared after emit");

    send_pfx(32'h7FFF0001, "R11 prefix quiet");
    send_pfx(32'h80000002, "R11 prefix quiet");
    consume(0, 21'h0FFFFF, 8'h3C, expect_const(0, 21'h0FFFFF), "R2 flag clear ignores pending");
    consume(1, 21'h0FFFFF, 8'h3D, expect_const(0, 21'h0FFFFF), "R8 pending dropped");

    send_pfx(32'h12345678, "R11 prefix quiet");
    slot(1, 1, 1, 0, 32'h87654321, '0, '0, 1);
    chk({125'd0, o_valid, o_ovf, o_ser_err}, 128'd0, "R9 flush quiet");
    consume(1, 21'h000042, 8'h51, expect_const(0, 21'h000042), "R9 flush cleared");

    send_pfx(32'h0000ABCD, "R11 prefix quiet");
    slot(1, 1, 0, 0, 32'h11112222, '0, '0, 0);
    chk({125'd0, o_valid, o_ovf, o_ser_err}, 128'd1, "R10 prefix without break");
    consume(1, 21'h1F0000, 8'h61, expect_const(0, 21'h1F0000), "R10 pending cleared");
    pays[0] = 32'h00C0FFEE;
    send_pfx(pays[0], "R11 prefix quiet");
    slot(1, 0, 0, 1, '0, 21'h00007, 8'h62, 0);
    chk({125'd0, o_valid, o_ovf, o_ser_err}, 128'd1, "R10 consumer without break");
    slot(1, 0, 0, 0, '0, 21'h000009, 8'h63, 0);
    chk({125'd0, o_valid, o_ovf, o_ser_err}, 128'd4, "R10 unflagged consumer needs no break");
    chk(o_const, expect_const(0, 21'h000009), "R10 unflagged consumer value");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule